// File: doc/BRIEF.md
# Single-Bit ECC Error Address Log

This block keeps a short record of where correctable single-bit ECC errors occurred in external memory. The read-data path of a memory controller raises a one-cycle error strobe together with the bus address of the burst that failed. The block converts that bus address into the controller's burst-aligned logged form and holds up to two such entries in a small queue, oldest first.

Software sees the oldest entry through a register read port. Writing the value 0x1 to the log register discards that entry, and the next one becomes visible. While the queue is full, further errors are not logged. A saturating counter records how many errors were lost this way. Identical addresses are never merged.

The error input has no back-pressure. An error is never stalled. It is either stored in the cycle it arrives or counted as dropped. The read port shows the head combinationally, one cycle after the clock edge that changed it.

Top module: `ecc_err_addr_log`

## Requirements
- R1: After reset the queue is empty (`log_empty`=1, `log_full`=0), `log_rd_data` reads 0 and `drop_cnt` is 0.
- R2: A logged entry equals ((err_addr − 0x8000_0000) mod 2^32) shifted right by one, with bits [4:0] then cleared. For example, 0xBEFFFF00 is logged as 0x1F7FFF80, 0xBEFFFFFF as 0x1F7FFFE0, and 0x90000000 as 0x08000000.
- R3: `log_rd_data` shows the oldest stored entry. It is visible in the cycle after the strobe's clock edge and stays unchanged until it is popped.
- R4: A cycle with `reg_wr_en`=1 and `reg_wr_data`=0x1, while the queue is not empty, removes the head entry, and the next stored entry becomes visible.
- R5: A register write whose data is any value other than 0x1 changes neither the entries, the flags nor the drop count.
- R6: While the queue is empty, `log_rd_data` reads 0 and a pop write is ignored.
- R7: The queue keeps the first two errors. An error that arrives while two entries are held (and no pop occurs in that cycle) is not stored.
- R8: No comparison is made between addresses, so two errors at the same address yield two identical entries.
- R9: When a pop and an error occur in the same cycle, the pop is applied first and the new address is then stored. A full queue therefore stays full and accepts the new entry.
- R10: `drop_cnt` increases by one for each error not stored, and it holds at its maximum (255 for the default 8-bit width).
- R11: `log_full` is 1 exactly when two entries are held, and `log_empty` is 1 exactly when none are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_vld | input | 1 | One-cycle strobe for a correctable single-bit error |
| err_addr | input | 32 | Bus address of the failing access |
| reg_wr_en | input | 1 | Write strobe to the log register |
| reg_wr_data | input | 32 | Write data; 0x1 pops the head entry |
| log_rd_data | output | 32 | Head entry of the queue, 0 when empty |
| log_full | output | 1 | Queue holds two entries |
| log_empty | output | 1 | Queue holds no entries |
| drop_cnt | output | 8 | Saturating count of errors not logged |

## Verification
The bench aims at the edges of the two-entry queue. It strikes a third error into a full log, which a design that overwrote entries would show as a changed head. It writes a pop to an empty log, which a design that underflowed would show as a wrong count or flags. It issues a pop and an error in the same cycle when the log is full and when it is empty; a design with the wrong order would either drop the address or lose it. It also checks that non-0x1 writes leave everything untouched, that repeated identical addresses fill both slots, and that the address conversion wraps below the base and clears the burst offset bits. Finally, it drives enough errors into a full log to show that the drop counter stops at its maximum instead of wrapping to zero.

// File: rtl/eal_pkg.sv
package eal_pkg;
  // Queue action for one cycle, formed from accepted pop and push.
  typedef enum logic [1:0] {
    EAL_IDLE = 2'b00,
    EAL_POP  = 2'b01,
    EAL_PUSH = 2'b10,
    EAL_SWAP = 2'b11
  } eal_op_e;
endpackage

// File: rtl/eal_addr_xlate.sv
module eal_addr_xlate #(
  parameter int unsigned ADDR_W     = 32,
  parameter logic [ADDR_W-1:0] BASE = 32'h8000_0000,
  parameter int unsigned SHIFT      = 1,
  parameter int unsigned ALIGN_BITS = 5
) (
  input  logic [ADDR_W-1:0] bus_addr_i,
  output logic [ADDR_W-1:0] log_addr_o
);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~((ADDR_W'(1) << ALIGN_BITS) - ADDR_W'(1));

  logic [ADDR_W-1:0] offset;
  logic [ADDR_W-1:0] scaled;

  always_comb begin
    offset     = bus_addr_i - BASE;
    scaled     = offset >> SHIFT;
    log_addr_o = scaled & ALIGN_MASK;
  end
endmodule

// File: rtl/eal_queue.sv
module eal_queue
  import eal_pkg::*;
#(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         full_o,
  output logic         empty_o,
  output logic         drop_o
);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_mid;
  logic          pop_ok;
  logic          push_ok;
  eal_op_e       op;
  logic [W-1:0]  slot    [DEPTH];
  logic [W-1:0]  shift_d [DEPTH];

  always_comb begin
    pop_ok  = pop_i && (cnt_q != '0);
    cnt_mid = cnt_q - CW'(pop_ok);
    push_ok = push_i && (cnt_mid < CW'(DEPTH));
    op      = eal_op_e'({push_ok, pop_ok});
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [W-1:0] q;
    if (i == DEPTH - 1) begin : g_tail
      assign shift_d[i] = pop_ok ? '0 : q;
    end else begin : g_mid
      assign shift_d[i] = pop_ok ? slot[i+1] : q;
    end
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        q <= '0;
      end else if (push_ok && (cnt_mid == CW'(i))) begin
        q <= din_i;
      end else begin
        q <= shift_d[i];
      end
    end
    assign slot[i] = q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      case (op)
        EAL_PUSH: cnt_q <= cnt_q + CW'(1);
        EAL_POP:  cnt_q <= cnt_q - CW'(1);
        default:  cnt_q <= cnt_q;
      endcase
    end
  end

  assign head_o  = slot[0];
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign drop_o  = push_i && !push_ok;

  // R3
  head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pop_i && !empty_o) |=> $stable(head_o));

  if (DEPTH > 1) begin : g_pop_chk
    // R4
    pop_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_i && cnt_q >= CW'(2)) |=> (head_o == $past(slot[1])));
  end

  // R7
  full_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && !pop_i) |=> (full_o && $stable(head_o)));
endmodule

// File: rtl/eal_sat_cnt.sv
module eal_sat_cnt #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_o <= '0;
    end else if (inc_i && (cnt_o != CNT_MAX)) begin
      cnt_o <= cnt_o + CNT_W'(1);
    end
  end

  // R10
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_o == CNT_MAX) |=> (cnt_o == CNT_MAX));
endmodule

// File: rtl/ecc_err_addr_log.sv
module ecc_err_addr_log #(
  parameter int unsigned ADDR_W     = 32,
  parameter logic [ADDR_W-1:0] BASE = 32'h8000_0000,
  parameter int unsigned SHIFT      = 1,
  parameter int unsigned ALIGN_BITS = 5,
  parameter int unsigned DEPTH      = 2,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned CNT_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              err_vld,
  input  logic [ADDR_W-1:0] err_addr,
  input  logic              reg_wr_en,
  input  logic [DATA_W-1:0] reg_wr_data,
  output logic [ADDR_W-1:0] log_rd_data,
  output logic              log_full,
  output logic              log_empty,
  output logic [CNT_W-1:0]  drop_cnt
);
  localparam logic [DATA_W-1:0] POP_CODE = DATA_W'(1);

  logic [ADDR_W-1:0] logged_addr;
  logic              pop_req;
  logic              dropped;

  assign pop_req = reg_wr_en && (reg_wr_data == POP_CODE);

  eal_addr_xlate #(
    .ADDR_W(ADDR_W), .BASE(BASE), .SHIFT(SHIFT), .ALIGN_BITS(ALIGN_BITS)
  ) u_xlate (
    .bus_addr_i(err_addr),
    .log_addr_o(logged_addr)
  );

  eal_queue #(.W(ADDR_W), .DEPTH(DEPTH)) u_queue (
    .clk(clk), .rst_n(rst_n),
    .push_i(err_vld), .din_i(logged_addr), .pop_i(pop_req),
    .head_o(log_rd_data), .full_o(log_full), .empty_o(log_empty),
    .drop_o(dropped)
  );

  eal_sat_cnt #(.CNT_W(CNT_W)) u_drops (
    .clk(clk), .rst_n(rst_n), .inc_i(dropped), .cnt_o(drop_cnt)
  );

  // R11
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(log_full && log_empty));

  // R6
  empty_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    log_empty |-> (log_rd_data == '0));

  // R7
  drop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_vld || !log_full || pop_req) |=> $stable(drop_cnt));

  // R9
  swap_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_vld && pop_req && log_full) |=> (log_full && $stable(drop_cnt)));
endmodule

// File: tb/test_ecc_err_addr_log.sv
module test_ecc_err_addr_log;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        err_vld = 1'b0;
  logic [31:0] err_addr = '0;
  logic        reg_wr_en = 1'b0;
  logic [31:0] reg_wr_data = '0;
  logic [31:0] log_rd_data;
  logic        log_full, log_empty;
  logic [7:0]  drop_cnt;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] exp_q[$];
  int          exp_drop = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ecc_err_addr_log i_ecc_err_addr_log (
    .clk(clk), .rst_n(rst_n), .err_vld(err_vld), .err_addr(err_addr),
    .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
    .log_rd_data(log_rd_data), .log_full(log_full), .log_empty(log_empty),
    .drop_cnt(drop_cnt)
  );

  function automatic logic [31:0] to_log(input logic [31:0] a);
    logic [31:0] d;
    d = (a - 32'h8000_0000) >> 1;
    return d & 32'hFFFF_FFE0;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // Monitor side: compare design state against the scoreboard model.
  task automatic compare(input string req);
    logic [31:0] eh;
    eh = (exp_q.size() != 0) ? exp_q[0] : 32'h0;
    check(log_rd_data == eh, req, log_rd_data, eh);
    check(log_empty == (exp_q.size() == 0), {req, " R11 empty"}, 32'(log_empty), 32'(exp_q.size() == 0));
    check(log_full == (exp_q.size() == 2), {req, " R11 full"}, 32'(log_full), 32'(exp_q.size() == 2));
    check(drop_cnt == 8'(exp_drop), {req, " R10 drops"}, 32'(drop_cnt), 32'(exp_drop));
  endtask

  // Driver: one cycle of stimulus, model updated pop-first then push.
  task automatic drive(input bit e, input logic [31:0] a, input bit w, input logic [31:0] d);
    err_vld = e; err_addr = a; reg_wr_en = w; reg_wr_data = d;
    @(negedge clk);
    err_vld = 0; reg_wr_en = 0;
    if (w && d == 32'h1 && exp_q.size() != 0) void'(exp_q.pop_front());
    if (e) begin
      if (exp_q.size() < 2) exp_q.push_back(to_log(a));
      else if (exp_drop < 255) exp_drop++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1 reset");

    drive(1, 32'hBEFF_FF00, 0, 0);
    check(log_rd_data == 32'h1F7F_FF80, "R2 map 0xBEFFFF00", log_rd_data, 32'h1F7F_FF80);
    compare("R3 first entry");
    drive(1, 32'hBEFF_FFFF, 0, 0);
    compare("R3 head kept after second");
    drive(1, 32'h9000_0000, 0, 0);
    compare("R7 drop while full");
    drive(0, 0, 1, 32'h2);
    compare("R5 write 0x2 ignored");
    drive(0, 0, 1, 32'h101);
    compare("R5 write 0x101 ignored");
    drive(0, 0, 1, 32'h1);
    check(log_rd_data == 32'h1F7F_FFE0, "R2 map 0xBEFFFFFF", log_rd_data, 32'h1F7F_FFE0);
    compare("R4 pop shows next");
    drive(0, 0, 1, 32'h1);
    compare("R4 pop to empty");
    drive(0, 0, 1, 32'h1);
    compare("R6 pop on empty ignored");

    drive(1, 32'h9000_0000, 0, 0);
    check(log_rd_data == 32'h0800_0000, "R2 map 0x90000000", log_rd_data, 32'h0800_0000);
    drive(1, 32'h9000_0000, 0, 0);
    compare("R8 duplicate stored");
    drive(0, 0, 1, 32'h1);
    compare("R8 second copy");
    drive(0, 0, 1, 32'h1);
    compare("R6 empty reads zero");

    drive(1, 32'h0000_0040, 0, 0);
    compare("R2 wrap below base");
    drive(1, 32'hC000_001F, 0, 0);
    compare("R2 offset bits cleared");
    drive(1, 32'hA123_4567, 1, 32'h1);
    compare("R9 pop and error when full");
    drive(0, 0, 1, 32'h1);
    compare("R9 new entry at tail");
    drive(0, 0, 1, 32'h1);
    compare("R4 drain");
    drive(1, 32'h8800_0100, 1, 32'h1);
    compare("R9 pop and error when empty");
    drive(1, 32'h8800_0200, 0, 0);
    compare("R11 full again");

    for (int i = 0; i < 300; i++) begin
      drive(1, 32'h8000_0000 + 32'(i) * 32'h40, 0, 0);
    end
    compare("R10 saturation");
    check(drop_cnt == 8'hFF, "R10 held at max", 32'(drop_cnt), 32'hFF);
    drive(0, 0, 1, 32'h1);
    compare("R10 count kept after pop");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule